// File: doc/BRIEF.md
# Single-Cycle Register Processor Core

This block is a small processor that executes one instruction per clock. There is no pipeline and instructions run strictly in program order. The block holds its own program counter, a general register file, an instruction store and a separate data store. Its instruction set has six kinds of instruction:

- load an 8-bit constant
- copy the program counter into a register
- a register-to-register arithmetic or logic operation
- a conditional register-indirect jump
- a load from data memory
- a store to data memory

A spare opcode stops the machine.

The program is written into the instruction store through a write port, normally while reset is held. When reset is released the core starts fetching at address zero. It runs until it reaches a stop instruction, which freezes the program counter and raises `halted`. The surrounding logic can then read any register through a combinational debug port.

Top module: `mini_cpu`

## Requirements
- R1: While reset (`rst_n` low) is held, the program counter is zero and every register reads zero through the debug port. `halted` therefore reflects the instruction stored at address 0.
- R2: Each instruction takes exactly one clock edge. A straight-line program of N instructions followed by a stop raises `halted` after exactly N rising edges from reset release.
- R3: The instruction word is [15:13] opcode, [12:10] rd, [9:7] rs1, [6:4] rs2, [2:0] ALU function, and [7:0] constant. Opcode 0 writes rd with the constant zero-extended.
- R4: Opcode 1 writes rd with the address of that instruction, zero-extended.
- R5: Opcode 2 writes rd with f(rs1, rs2). The function codes are: 0 add, 1 subtract (rs1-rs2), 2 AND, 3 OR, 4 XOR, 5 signed less-than (result 1 or 0). Codes 6 and 7 give 0. Arithmetic wraps at the register width.
- R6: Opcode 3 with rs1 holding zero loads the program counter with the low address bits of rs2, and writes no register.
- R7: Opcode 3 with rs1 nonzero, and every opcode from 0 to 5 other than a taken jump, advances the program counter by one.
- R8: Opcode 5 stores rs2 at data address rs1. Opcode 4 writes rd with the data word at address rs1, in the same cycle it executes. Each address uses the low address bits of the register.
- R9: Opcodes 6 and 7 stop the core. While stopped, the program counter holds, no register is written, and `halted` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_addr | input | $clog2(IMEM_DEPTH) | Instruction store write address |
| imem_wdata | input | 16 | Instruction word to write |
| dbg_addr | input | $clog2(NREG) | Register index for the debug read |
| dbg_data | output | XLEN | Value of the selected register |
| halted | output | 1 | High while the current instruction is a stop |

## Verification
The bench builds the core with its defaults: 16-bit registers, eight of them, a 64-word instruction store and a 256-word data store. The 16-bit width lets a subtraction go negative, so the signed less-than is tested against values whose top bit differs. The 64-word store holds a counted loop with backward jumps, which exercises taken and untaken jumps many times over. Cycle counts up to the stop instruction confirm one instruction per edge.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

    localparam int ILEN = 16;

    typedef enum logic [2:0] {
        OP_LDC  = 3'd0,
        OP_LDPC = 3'd1,
        OP_ALU  = 3'd2,
        OP_JZ   = 3'd3,
        OP_LD   = 3'd4,
        OP_ST   = 3'd5,
        OP_STP6 = 3'd6,
        OP_STP7 = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_XOR = 3'd4,
        FN_SLT = 3'd5,
        FN_R6  = 3'd6,
        FN_R7  = 3'd7
    } alu_fn_e;

endpackage

// File: rtl/mcpu_imem.sv
module mcpu_imem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/mcpu_dmem.sv
module mcpu_dmem #(
    parameter int DEPTH = 256,
    parameter int XLEN  = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);
    logic [XLEN-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
    parameter int NREG = 8,
    parameter int XLEN = 16,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RAW-1:0]  ra1,
    output logic [XLEN-1:0] rd1,
    input  logic [RAW-1:0]  ra2,
    output logic [XLEN-1:0] rd2,
    input  logic [RAW-1:0]  ra3,
    output logic [XLEN-1:0] rd3
);
    logic [NREG-1:0][XLEN-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];
    assign rd3 = regs_q[ra3];
endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
    import mcpu_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  alu_fn_e         fn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    always_comb begin
        case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/mini_cpu.sv
module mini_cpu
    import mcpu_pkg::*;
#(
    parameter int XLEN       = 16,
    parameter int NREG       = 8,
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_DEPTH)-1:0] imem_addr,
    input  logic [ILEN-1:0]               imem_wdata,
    input  logic [$clog2(NREG)-1:0]       dbg_addr,
    output logic [XLEN-1:0]               dbg_data,
    output logic                          halted
);
    localparam int IAW = $clog2(IMEM_DEPTH);
    localparam int DAW = $clog2(DMEM_DEPTH);
    localparam int RAW = $clog2(NREG);

    typedef struct packed {
        logic [IAW-1:0] pc;
    } core_t;

    core_t          st_d, st_q;
    logic [IAW-1:0] pc_q;
    logic [ILEN-1:0] instr;
    opcode_e        op;
    alu_fn_e        fn;
    logic [RAW-1:0] rd_idx, rs1_idx, rs2_idx;
    logic [7:0]     imm;
    logic [XLEN-1:0] rd1, rd2, alu_y, dm_rdata;
    logic           rf_we, dm_we;
    logic [XLEN-1:0] rf_wdata;

    assign pc_q = st_q.pc;

    mcpu_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(ILEN)) u_imem (
        .clk(clk), .we(imem_we), .waddr(imem_addr), .wdata(imem_wdata),
        .raddr(pc_q), .rdata(instr)
    );

    assign op      = opcode_e'(instr[15:13]);
    assign rd_idx  = RAW'(instr[12:10]);
    assign rs1_idx = RAW'(instr[9:7]);
    assign rs2_idx = RAW'(instr[6:4]);
    assign fn      = alu_fn_e'(instr[2:0]);
    assign imm     = instr[7:0];

    mcpu_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rd_idx), .wdata(rf_wdata),
        .ra1(rs1_idx), .rd1(rd1), .ra2(rs2_idx), .rd2(rd2),
        .ra3(dbg_addr), .rd3(dbg_data)
    );

    mcpu_alu #(.XLEN(XLEN)) u_alu (.fn(fn), .a(rd1), .b(rd2), .y(alu_y));

    mcpu_dmem #(.DEPTH(DMEM_DEPTH), .XLEN(XLEN)) u_dmem (
        .clk(clk), .we(dm_we), .addr(rd1[DAW-1:0]), .wdata(rd2), .rdata(dm_rdata)
    );

    always_comb begin
        st_d     = st_q;
        st_d.pc  = pc_q + 1'b1;
        rf_we    = 1'b0;
        rf_wdata = '0;
        dm_we    = 1'b0;
        halted   = 1'b0;
        case (op)
            OP_LDC: begin
                rf_we    = 1'b1;
                rf_wdata = XLEN'(imm);
            end
            OP_LDPC: begin
                rf_we    = 1'b1;
                rf_wdata = XLEN'(pc_q);
            end
            OP_ALU: begin
                rf_we    = 1'b1;
                rf_wdata = alu_y;
            end
            OP_JZ: begin
                if (rd1 == '0) st_d.pc = rd2[IAW-1:0];
            end
            OP_LD: begin
                rf_we    = 1'b1;
                rf_wdata = dm_rdata;
            end
            OP_ST: begin
                dm_we = 1'b1;
            end
            default: begin
                st_d.pc = pc_q;
                halted  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mini_cpu_chk.sv
module mini_cpu_chk #(
    parameter int IAW  = 6,
    parameter int XLEN = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [IAW-1:0]  pc_q,
    input logic [2:0]      op,
    input logic [XLEN-1:0] rs1_val,
    input logic [IAW-1:0]  rs2_low,
    input logic            rf_we,
    input logic [XLEN-1:0] rf_wdata,
    input logic [7:0]      imm,
    input logic            halted
);
    AST_STOP_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> pc_q == $past(pc_q)); // R9
    AST_STOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !rf_we); // R9
    AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 && rs1_val == '0) |=> pc_q == $past(rs2_low)); // R6
    AST_JUMP_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 && rs1_val != '0) |=> pc_q == IAW'($past(pc_q) + 1'b1)); // R7
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (op <= 3'd5 && op != 3'd3) |=> pc_q == IAW'($past(pc_q) + 1'b1)); // R7
    AST_CONST_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd0) |-> (rf_we && rf_wdata == XLEN'(imm))); // R3
    AST_PC_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1) |-> (rf_we && rf_wdata == XLEN'(pc_q))); // R4
endmodule

bind mini_cpu mini_cpu_chk #(.IAW(IAW), .XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc_q(pc_q), .op(op), .rs1_val(rd1),
    .rs2_low(rd2[IAW-1:0]), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .imm(imm), .halted(halted)
);

// File: tb/mini_cpu_test.sv
`timescale 1ns/100ps
module mini_cpu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_addr = '0;
    logic [15:0] imem_wdata = '0;
    logic [2:0]  dbg_addr = '0;
    logic [15:0] dbg_data;
    logic        halted;
    int errors = 0;
    int checks = 0;
    int cyc = 0;
    localparam logic [15:0] STOP = 16'hE000;

    mini_cpu uut (
        .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
        .halted(halted)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [15:0] e_ldc(int rd, int v);
        return {3'd0, 3'(rd), 2'b00, 8'(v)};
    endfunction
    function automatic logic [15:0] e_ldpc(int rd);
        return {3'd1, 3'(rd), 10'd0};
    endfunction
    function automatic logic [15:0] e_alu(int f, int rd, int a, int b);
        return {3'd2, 3'(rd), 3'(a), 3'(b), 1'b0, 3'(f)};
    endfunction
    function automatic logic [15:0] e_jz(int a, int b);
        return {3'd3, 3'd0, 3'(a), 3'(b), 4'd0};
    endfunction
    function automatic logic [15:0] e_ld(int rd, int a);
        return {3'd4, 3'(rd), 3'(a), 7'd0};
    endfunction
    function automatic logic [15:0] e_st(int a, int b);
        return {3'd5, 3'd0, 3'(a), 3'(b), 4'd0};
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(int a, logic [15:0] w);
        @(negedge clk);
        imem_we = 1'b1; imem_addr = 6'(a); imem_wdata = w;
        @(negedge clk);
        imem_we = 1'b0;
    endtask

    task automatic begin_prog();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) put(i, STOP);
    endtask

    task automatic run(string tag, int exp_cycles);
        int n = 0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        while (!halted && n < 1000) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk(tag, n, exp_cycles);
    endtask

    task automatic rreg(string tag, int idx, int exp);
        dbg_addr = 3'(idx);
        #0.5;
        chk(tag, int'(dbg_data), exp);
    endtask

    task automatic t_const();
        begin_prog();
        put(0, e_ldc(1, 8'hFF)); put(1, e_ldc(2, 8'h5A));
        put(2, e_ldc(1, 8'h12)); put(3, e_ldc(3, 0));
        run("R2 const cycles", 4);
        rreg("R3 r1 overwrite", 1, 16'h0012);
        rreg("R3 r2", 2, 16'h005A);
        rreg("R3 r3 zero", 3, 0);
        begin_prog();
        put(0, e_ldc(4, 8'hFF));
        run("R2 one instr", 1);
        rreg("R3 zero extend", 4, 16'h00FF);
    endtask

    task automatic t_alu();
        begin_prog();
        put(0, e_ldc(1, 8'hF0)); put(1, e_ldc(2, 8'h3C));
        put(2, e_alu(0, 3, 1, 2)); put(3, e_alu(1, 4, 1, 2));
        put(4, e_alu(1, 5, 2, 1)); put(5, e_alu(2, 6, 1, 2));
        put(6, e_alu(3, 7, 1, 2)); put(7, e_alu(4, 0, 1, 2));
        run("R2 alu cycles", 8);
        rreg("R5 add", 3, 16'h012C);
        rreg("R5 sub", 4, 16'h00B4);
        rreg("R5 sub wrap", 5, 16'hFF4C);
        rreg("R5 and", 6, 16'h0030);
        rreg("R5 or", 7, 16'h00FC);
        rreg("R5 xor", 0, 16'h00CC);
        begin_prog();
        put(0, e_ldc(1, 5)); put(1, e_alu(1, 2, 0, 1));
        put(2, e_alu(5, 3, 2, 1)); put(3, e_alu(5, 4, 1, 2));
        put(4, e_alu(5, 5, 1, 1)); put(5, e_ldc(6, 8'h77));
        put(6, e_alu(6, 6, 1, 1)); put(7, e_ldc(7, 8'h77));
        put(8, e_alu(7, 7, 1, 2));
        run("R2 slt cycles", 9);
        rreg("R5 negative", 2, 16'hFFFB);
        rreg("R5 slt neg<pos", 3, 1);
        rreg("R5 slt pos<neg", 4, 0);
        rreg("R5 slt equal", 5, 0);
        rreg("R5 fn6 zero", 6, 0);
        rreg("R5 fn7 zero", 7, 0);
    endtask

    task automatic t_pc();
        begin_prog();
        put(0, e_ldc(1, 9)); put(1, e_ldpc(2)); put(2, e_ldpc(3));
        run("R2 ldpc cycles", 3);
        rreg("R4 pc at 1", 2, 1);
        rreg("R4 pc at 2", 3, 2);
    endtask

    task automatic t_jump();
        begin_prog();
        put(0, e_ldc(1, 0)); put(1, e_ldc(2, 6)); put(2, e_jz(1, 2));
        put(3, e_ldc(4, 8'h11)); put(4, e_ldc(4, 8'h22));
        put(6, e_ldc(5, 8'h33));
        run("R6 taken cycles", 4);
        rreg("R6 skipped", 4, 0);
        rreg("R6 target ran", 5, 16'h0033);
        begin_prog();
        put(0, e_ldc(1, 1)); put(1, e_ldc(2, 6)); put(2, e_jz(1, 2));
        put(3, e_ldc(4, 8'h11)); put(6, e_ldc(5, 8'h33));
        run("R7 not taken cycles", 4);
        rreg("R7 fell through", 4, 16'h0011);
        rreg("R7 target not run", 5, 0);
        begin_prog();
        put(0, e_ldc(1, 3)); put(1, e_ldc(2, 1)); put(2, e_ldc(3, 9));
        put(3, e_ldc(5, 5)); put(4, e_ldc(6, 0)); put(5, e_jz(1, 3));
        put(6, e_alu(1, 1, 1, 2)); put(7, e_alu(0, 6, 6, 2));
        put(8, e_jz(0, 5));
        run("R6 R7 loop cycles", 18);
        rreg("R7 loop count", 6, 3);
        rreg("R6 loop exit", 1, 0);
    endtask

    task automatic t_mem();
        begin_prog();
        put(0, e_ldc(1, 8'h10)); put(1, e_ldc(2, 8'hAB)); put(2, e_st(1, 2));
        put(3, e_ldc(3, 8'h11)); put(4, e_ldc(4, 8'hCD)); put(5, e_st(3, 4));
        put(6, e_ld(5, 1)); put(7, e_ld(6, 3));
        put(8, e_alu(1, 7, 0, 2)); put(9, e_st(1, 7)); put(10, e_ld(0, 1));
        run("R8 mem cycles", 11);
        rreg("R8 load a", 5, 16'h00AB);
        rreg("R8 load b", 6, 16'h00CD);
        rreg("R8 rewrite", 0, 16'hFF55);
    endtask

    task automatic t_stop();
        begin_prog();
        put(0, e_ldc(1, 7)); put(1, 16'hC000);
        put(2, e_ldc(1, 9)); put(3, e_ldc(2, 9));
        run("R9 stop cycles", 1);
        repeat (10) @(negedge clk);
        #1;
        chk("R9 still halted", int'(halted), 1);
        rreg("R9 r1 held", 1, 7);
        rreg("R9 r2 untouched", 2, 0);
    endtask

    task automatic t_reset();
        begin_prog();
        put(0, e_ldc(1, 8'h44)); put(1, e_ldc(7, 8'h66));
        run("R2 pre reset", 2);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        for (int i = 0; i < 8; i++) rreg("R1 reg zero", i, 0);
        chk("R1 pc zero fetch", int'(halted), 0);
        put(0, STOP);
        #1;
        chk("R1 pc zero halted", int'(halted), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rreg("R1 initial r0", 0, 0);
        t_const();
        t_alu();
        t_pc();
        t_jump();
        t_mem();
        t_stop();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule